// File: doc/BRIEF.md
# Multi-Cycle Six-Instruction Processor Core

This block is a small 32-bit processor core. It executes one stage of an instruction per clock: fetch, decode with register read, execute, memory access and register write-back. A control state machine steps through these stages and skips any stage that the current instruction does not need. The number of cycles per instruction therefore varies: a load takes five, a branch three. Holding registers between the stages carry the instruction word, the two operands, the ALU result and the loaded word from one stage to the next.

The core has one memory port. It serves instruction fetch and data access at different times, so only one access takes place per cycle. Reads from the port are combinational. Writes take effect on the clock edge when the write strobe is high. The core drives a stage code and a one-cycle retire strobe, so an external observer can count cycles per instruction. The instruction set is add, subtract, OR with an immediate, load word, store word and branch-if-equal, in a fixed 32-bit format.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, asynchronously and without waiting for a clock, `stage` is 0, the program counter is 0, `mem_addr` is 0, and `mem_we` and `retire` are 0. The first fetch after release reads address 0.
- R2: `stage` encodes fetch=0, decode=1, execute=2, memory=3, write-back=4. Fetch lasts one cycle with `mem_addr` equal to the PC. It captures `mem_rdata` as the instruction and advances the PC by 4. Decode always follows fetch, and execute always follows decode.
- R3: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift field [10:6], function code [5:0], immediate [15:0]. The opcodes are: register-register 0x00, with function code 0x21 for add or 0x23 for subtract and a shift field of 0; OR-immediate 0x0D; load 0x23; store 0x2B; branch-if-equal 0x04.
- R4: Add and subtract write rs+rt or rs-rt, modulo 2^32, into rd. They take 4 cycles and retire in stage 4.
- R5: OR-immediate writes rs OR the zero-extended immediate into rt. It takes 4 cycles and retires in stage 4.
- R6: A load reads the word at rs plus the sign-extended immediate and writes it into rt. It takes 5 cycles, passes through all five stages in order, and retires in stage 4.
- R7: A store writes rt to address rs plus the sign-extended immediate. `mem_we` is high for exactly the one memory-stage cycle. The store takes 4 cycles, retires in stage 3 and writes no register.
- R8: Branch-if-equal takes 3 cycles and retires in stage 2. If rs equals rt, the next fetch is at PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next fetch is at PC+4.
- R9: `retire` is high for exactly one cycle per instruction, on its last stage, and the following cycle is a fetch.
- R10: Register 0 always reads as zero, and writes to it are ignored.
- R11: Any other encoding, including a register-register word with an unlisted function code or a nonzero shift field, retires in execute after 3 cycles. It writes neither a register nor memory and continues at PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| mem_addr | output | 32 | Byte address of the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, high in a store's memory stage |
| mem_rdata | input | 32 | Combinational read data for `mem_addr` |
| stage | output | 3 | Current stage, 0 fetch to 4 write-back |
| retire | output | 1 | High on the last stage of each instruction |

## Verification
Some properties hold on every cycle and are checked by assertions. The stage code stays in its legal range. Decode always follows fetch and execute always follows decode. Every retire is followed by a fetch. Fetch advances the PC by 4, and an untaken branch leaves the PC unchanged. A store strobe coincides with retire, and a load reaches write-back only through the memory stage.

Other behaviour can only be shown by the bench's program. That program checks the actual cycle count and retire stage of each instruction kind. It checks where the PC goes after a taken or untaken branch, including a branch back to itself. It checks the arithmetic results, zero versus sign extension and negative load offsets, which it reads back through stores. It also checks that writes to register 0 are discarded, that unknown encodings have no effect, and that a reset in mid-instruction takes effect at once.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int ILEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BREQ = 6'h04;
  localparam logic [5:0] FN_ADD  = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h23;

  typedef enum logic [2:0] {
    ST_IF  = 3'd0,
    ST_ID  = 3'd1,
    ST_EX  = 3'd2,
    ST_MEM = 3'd3,
    ST_WB  = 3'd4
  } stage_e;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_ORI, K_LOAD, K_STOR, K_BREQ, K_BAD
  } kind_e;

  typedef enum logic [1:0] {
    A_ADD, A_SUB, A_OR
  } aluop_e;

  function automatic kind_e classify(input logic [ILEN-1:0] ins);
    kind_e k;
    k = K_BAD;
    case (ins[31:26])
      OP_REG: begin
        if (ins[10:6] == 5'd0 && ins[5:0] == FN_ADD) k = K_ADD;
        else if (ins[10:6] == 5'd0 && ins[5:0] == FN_SUB) k = K_SUB;
      end
      OP_ORI:  k = K_ORI;
      OP_LOAD: k = K_LOAD;
      OP_STOR: k = K_STOR;
      OP_BREQ: k = K_BREQ;
      default: k = K_BAD;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W      = 32,
  parameter int N_REGS = 32
) (
  input  logic                      clk,
  input  logic [$clog2(N_REGS)-1:0] ra,
  input  logic [$clog2(N_REGS)-1:0] rb,
  output logic [W-1:0]              rda,
  output logic [W-1:0]              rdb,
  input  logic                      we,
  input  logic [$clog2(N_REGS)-1:0] wa,
  input  logic [W-1:0]              wd
);
  localparam int AW = $clog2(N_REGS);

  logic [W-1:0] regs [N_REGS];

  // entry 0 is never stored; it reads as zero
  for (genvar g = 1; g < N_REGS; g++) begin : g_entry
    logic ent_en;
    assign ent_en = we && (wa == AW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) regs[g] <= wd;
    end
  end

  assign rda = (ra == '0) ? '0 : regs[ra];
  assign rdb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluop_e       op,
  output logic [W-1:0] y,
  output logic         eq
);
  always_comb begin
    case (op)
      A_SUB:   y = a - b;
      A_OR:    y = a | b;
      default: y = a + b;
    endcase
  end
  assign eq = (a == b);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  kind_e  kind,
  output stage_e st,
  output logic   retire
);
  stage_e st_nx;

  always_comb begin
    case (st)
      ST_IF: st_nx = ST_ID;
      ST_ID: st_nx = ST_EX;
      ST_EX: begin
        if (kind == K_BREQ || kind == K_BAD)        st_nx = ST_IF;
        else if (kind == K_LOAD || kind == K_STOR)  st_nx = ST_MEM;
        else                                        st_nx = ST_WB;
      end
      ST_MEM:  st_nx = (kind == K_LOAD) ? ST_WB : ST_IF;
      default: st_nx = ST_IF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IF;
    else        st <= st_nx;
  end

  assign retire = (st == ST_WB) ||
                  (st == ST_MEM && kind == K_STOR) ||
                  (st == ST_EX && (kind == K_BREQ || kind == K_BAD));

  // R9
  retire_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (st == ST_IF));
  // R2
  stage_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st <= ST_WB);
  // R2
  decode_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ID) |=> (st == ST_EX));
  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IF) |=> (st == ST_ID));
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter int          XLEN     = 32,
  parameter int          N_REGS   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [2:0]      stage,
  output logic            retire
);
  localparam int AW = $clog2(N_REGS);
  localparam int XW = XLEN - 16;

  stage_e          st;
  kind_e           kind;
  aluop_e          aop;
  logic [XLEN-1:0] pc, ir, a_q, b_q, alu_q, mdr;
  logic [XLEN-1:0] rda, rdb, alu_b, alu_y, imm_s, imm_z, br_off;
  logic            alu_eq;
  logic            ir_en, opr_en, res_en, mdr_en, pc_en, rf_we, br_take;
  logic [AW-1:0]   wa;
  logic [XLEN-1:0] wd, pc_nx;

  assign kind   = classify(ir);
  assign imm_s  = {{XW{ir[15]}}, ir[15:0]};
  assign imm_z  = {{XW{1'b0}}, ir[15:0]};
  assign br_off = {imm_s[XLEN-3:0], 2'b00};

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .kind(kind), .st(st), .retire(retire)
  );

  mc_regfile #(.W(XLEN), .N_REGS(N_REGS)) u_rf (
    .clk(clk), .ra(ir[25:21]), .rb(ir[20:16]), .rda(rda), .rdb(rdb),
    .we(rf_we), .wa(wa), .wd(wd)
  );

  always_comb begin
    case (kind)
      K_SUB, K_BREQ: aop = A_SUB;
      K_ORI:         aop = A_OR;
      default:       aop = A_ADD;
    endcase
    case (kind)
      K_ORI:          alu_b = imm_z;
      K_LOAD, K_STOR: alu_b = imm_s;
      default:        alu_b = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a(a_q), .b(alu_b), .op(aop), .y(alu_y), .eq(alu_eq)
  );

  // stage clock enables
  assign ir_en   = (st == ST_IF);
  assign opr_en  = (st == ST_ID);
  assign res_en  = (st == ST_EX);
  assign mdr_en  = (st == ST_MEM) && (kind == K_LOAD);
  assign br_take = (st == ST_EX) && (kind == K_BREQ) && alu_eq;
  assign pc_en   = ir_en || br_take;
  assign pc_nx   = ir_en ? pc + 32'd4 : pc + br_off;

  assign rf_we = (st == ST_WB);
  assign wa    = (kind == K_ADD || kind == K_SUB) ? ir[15:11] : ir[20:16];
  assign wd    = (kind == K_LOAD) ? mdr : alu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= RESET_PC;
      ir    <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
      mdr   <= '0;
    end else begin
      if (pc_en)  pc    <= pc_nx;
      if (ir_en)  ir    <= mem_rdata;
      if (opr_en) a_q   <= rda;
      if (opr_en) b_q   <= rdb;
      if (res_en) alu_q <= alu_y;
      if (mdr_en) mdr   <= mem_rdata;
    end
  end

  assign mem_addr  = (st == ST_MEM) ? alu_q : pc;
  assign mem_wdata = b_q;
  assign mem_we    = (st == ST_MEM) && (kind == K_STOR);
  assign stage     = st;

  // R2
  fetch_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IF) |=> (pc == $past(pc) + 32'd4));
  // R8
  beq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EX && kind == K_BREQ && a_q != b_q) |=> (pc == $past(pc)));
  // R7
  store_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> retire);
  // R6
  load_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB && kind == K_LOAD) |-> ($past(st) == ST_MEM));
endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ins;
    logic [2:0]  cyc;
    logic [2:0]  lst;
  } vec_t;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{32'h00, enc_i(6'h0D, 0, 1, 16'h0005), 3'd4, 3'd4},
    '{32'h04, enc_i(6'h0D, 0, 2, 16'h0003), 3'd4, 3'd4},
    '{32'h08, enc_r(1, 2, 3, 6'h21),        3'd4, 3'd4},
    '{32'h0C, enc_r(2, 1, 4, 6'h23),        3'd4, 3'd4},
    '{32'h10, enc_i(6'h2B, 0, 3, 16'h0080), 3'd4, 3'd3},
    '{32'h14, enc_i(6'h2B, 0, 4, 16'h0084), 3'd4, 3'd3},
    '{32'h18, enc_i(6'h23, 0, 5, 16'h0080), 3'd5, 3'd4},
    '{32'h1C, enc_i(6'h0D, 0, 6, 16'hFFFF), 3'd4, 3'd4},
    '{32'h20, enc_i(6'h04, 3, 5, 16'h0001), 3'd3, 3'd2},
    '{32'h28, enc_i(6'h04, 1, 2, 16'h0001), 3'd3, 3'd2},
    '{32'h2C, enc_i(6'h2B, 0, 5, 16'h0088), 3'd4, 3'd3},
    '{32'h30, enc_i(6'h2B, 0, 6, 16'h008C), 3'd4, 3'd3},
    '{32'h34, enc_i(6'h0D, 0, 9, 16'h0090), 3'd4, 3'd4},
    '{32'h38, enc_i(6'h23, 9, 8, 16'hFFFC), 3'd5, 3'd4},
    '{32'h3C, enc_i(6'h2B, 0, 8, 16'h0090), 3'd4, 3'd3},
    '{32'h40, enc_r(1, 1, 0, 6'h21),        3'd4, 3'd4},
    '{32'h44, 32'hFC00_0000,                3'd3, 3'd2},
    '{32'h48, enc_i(6'h2B, 0, 0, 16'h0094), 3'd4, 3'd3},
    '{32'h4C, enc_i(6'h04, 0, 0, 16'hFFFF), 3'd3, 3'd2},
    '{32'h4C, enc_i(6'h04, 0, 0, 16'hFFFF), 3'd3, 3'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, retire;
  logic [2:0]  stage;
  logic [31:0] mem [64];
  int          n_tests = 0;
  int          n_fail = 0;
  int          n_we = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .stage(stage), .retire(retire)
  );

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:2]] <= mem_wdata;
      n_we <= n_we + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    for (int i = 0; i < NV; i++) mem[VEC[i].pc[7:2]] = VEC[i].ins;
    mem[9] = enc_i(6'h0D, 0, 7, 16'h0001);

    // R1 reset state
    @(negedge clk);
    chk("R1 stage", {29'd0, stage}, 32'd0);
    chk("R1 addr", mem_addr, 32'd0);
    chk("R1 strobes", {30'd0, mem_we, retire}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int k = 0; k < NV; k++) begin
      int n;
      chk("R2 fetch stage", {29'd0, stage}, 32'd0);
      chk("R8 fetch addr", mem_addr, VEC[k].pc);
      n = 1;
      while (!retire && n < 8) begin
        @(negedge clk);
        n++;
      end
      chk("R9 cycles", n, {29'd0, VEC[k].cyc});
      chk("R9 retire stage", {29'd0, stage}, {29'd0, VEC[k].lst});
      @(negedge clk);
    end

    // R4 add, R7 store data
    chk("R4 add", mem[32], 32'd8);
    chk("R4 sub wrap", mem[33], 32'hFFFF_FFFE);
    chk("R6 load", mem[34], 32'd8);
    chk("R5 zero extend", mem[35], 32'h0000_FFFF);
    chk("R6 negative offset", mem[36], 32'h0000_FFFF);
    chk("R10 r0 stays zero", mem[37], 32'h0);
    chk("R11 no stray write", mem[38], 32'h0);
    chk("R7 store strobe count", n_we, 32'd6);

    // R1 reset in mid-instruction
    @(negedge clk);
    chk("R2 decode stage", {29'd0, stage}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 async stage", {29'd0, stage}, 32'd0);
    chk("R1 async addr", mem_addr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 restart fetch", mem_addr, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule